// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst. A column command supplies a start column, a burst length code and an ordering flag. From the next clock on, the block presents one column address per cycle, with a valid flag, until the programmed number of beats has been issued.

The block supports two orderings. In sequential order, the address counts upward inside the aligned block that the burst length defines. In interleaved order, the low address bits are the start bits XORed with the beat number. A full-page burst always counts sequentially and wraps around the whole column range. It runs until a terminate request or a new command arrives.

A new column command may arrive on any cycle, including in the middle of a burst, and it restarts generation from its own start column. The column width is a parameter: 8 bits for a 256-column page or 9 bits for a 512-column page.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and after reset until the first command, `colValid` is 0.
- R2: On the cycle after `cmdValid` is high, `colValid` is 1 and `colOut` equals the `cmdCol` that was sampled. This holds on every cycle, whether or not a burst is in progress, and the new burst replaces the old one.
- R3: `cmdLen` sets the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. Codes 4, 5 and 6 give 1 beat. A burst that is not full page keeps `colValid` high for exactly that many consecutive cycles.
- R4: With `cmdInterleave` = 0, beat i outputs the start column with its low log2(BL) bits replaced by (start + i) mod BL. The upper bits stay unchanged.
- R5: With `cmdInterleave` = 1 and a length that is not full page, beat i outputs the start column with its low log2(BL) bits replaced by (start low bits) XOR i.
- R6: A full-page burst outputs (start + i) mod 2^COL_W on beat i and ignores `cmdInterleave`. It continues without limit until it is terminated or a new command arrives.
- R7: `termIn` high while `cmdValid` is low forces `colValid` to 0 on the next cycle. When both are high, the command wins. `termIn` has no effect while the block is idle.
- R8: A burst of length 1 outputs exactly one valid beat, equal to the start column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Column command strobe |
| cmdCol | input | COL_W | Start column of the command |
| cmdLen | input | 3 | Burst length code |
| cmdInterleave | input | 1 | 1 = interleaved order, 0 = sequential |
| termIn | input | 1 | Burst terminate request |
| colOut | output | COL_W | Column address of the current beat |
| colValid | output | 1 | colOut carries a beat |

## Verification
Every result arrives exactly one clock after the edge that samples its cause. The first beat appears one cycle after a command. Each later beat appears one cycle after the previous one. The drop of `colValid` after a terminate request, or after the last beat, also comes one cycle later. The bench drives inputs on the falling edge and lets one rising edge update its reference model. It then compares `colValid` and `colOut` on the next falling edge, so each check samples the cycle in which the response is due. Random command, terminate and length mixes sit alongside literal sequences for sequential wrap, interleaved order and full-page rollover.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Length codes on cmdLen
  localparam logic [2:0] LEN_1    = 3'd0;
  localparam logic [2:0] LEN_2    = 3'd1;
  localparam logic [2:0] LEN_4    = 3'd2;
  localparam logic [2:0] LEN_8    = 3'd3;
  localparam logic [2:0] LEN_PAGE = 3'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new command, beat count to zero
    logic step;   // advance to the next beat
  } bcgStrobe_t;

endpackage

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bcgStrobe_t       strobe,
  input  logic [COL_W-1:0] cmdCol,
  input  logic [2:0]       cmdLen,
  input  logic             cmdInterleave,
  output logic [COL_W-1:0] colOut,
  output logic             endOfBurst
);

  logic [COL_W-1:0] startCol;
  logic [COL_W-1:0] beatCnt;
  logic [COL_W-1:0] wrapMask;
  logic             fullPage;
  logic             ilvMode;

  logic [COL_W-1:0] loadMask;
  logic             loadFull;

  // Decode length code into a mask over the wrapping bits
  always_comb begin
    loadFull = (cmdLen == LEN_PAGE);
    unique case (cmdLen)
      LEN_2:    loadMask = COL_W'(1);
      LEN_4:    loadMask = COL_W'(3);
      LEN_8:    loadMask = COL_W'(7);
      LEN_PAGE: loadMask = '1;
      default:  loadMask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startCol <= '0;
      beatCnt  <= '0;
      wrapMask <= '0;
      fullPage <= 1'b0;
      ilvMode  <= 1'b0;
    end else if (strobe.load) begin
      startCol <= cmdCol;
      beatCnt  <= '0;
      wrapMask <= loadMask;
      fullPage <= loadFull;
      ilvMode  <= cmdInterleave & ~loadFull;
    end else if (strobe.step) begin
      beatCnt  <= beatCnt + 1'b1;
    end
  end

  logic [COL_W-1:0] lowSeq;
  logic [COL_W-1:0] lowIlv;

  always_comb begin
    lowSeq     = (startCol + beatCnt) & wrapMask;
    lowIlv     = (startCol ^ beatCnt) & wrapMask;
    colOut     = (startCol & ~wrapMask) | (ilvMode ? lowIlv : lowSeq);
    endOfBurst = !fullPage && (beatCnt == wrapMask);
  end

  // New command restarts from its own column
  assert_restart_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> colOut == $past(cmdCol));

  // Bits above the wrap window never move during a burst
  assert_upper_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && !fullPage) |=>
      ((colOut ^ $past(colOut)) & ~wrapMask) == '0);

  // Full page walks up by one and rolls over
  assert_page_increment_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.load && fullPage) |=>
      colOut == COL_W'($past(colOut) + 1'b1));

endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import burst_col_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic       termIn,
  input  logic       endOfBurst,
  output bcgStrobe_t strobe,
  output logic       colValid
);

  logic active;

  always_comb begin
    strobe.load = cmdValid;
    strobe.step = active & ~cmdValid & ~termIn & ~endOfBurst;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              active <= 1'b0;
    else if (cmdValid)      active <= 1'b1;
    else if (termIn)        active <= 1'b0;
    else if (endOfBurst)    active <= 1'b0;
  end

  assign colValid = active;

  assert_cmd_starts_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> colValid);

  assert_term_stops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (termIn && !cmdValid) |=> !colValid);

  assert_idle_after_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && endOfBurst && !cmdValid) |=> !colValid);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [COL_W-1:0] cmdCol,
  input  logic [2:0]       cmdLen,
  input  logic             cmdInterleave,
  input  logic             termIn,
  output logic [COL_W-1:0] colOut,
  output logic             colValid
);

  bcgStrobe_t strobe;
  logic       endOfBurst;

  bcg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .termIn     (termIn),
    .endOfBurst (endOfBurst),
    .strobe     (strobe),
    .colValid   (colValid)
  );

  bcg_datapath #(.COL_W(COL_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .cmdCol        (cmdCol),
    .cmdLen        (cmdLen),
    .cmdInterleave (cmdInterleave),
    .colOut        (colOut),
    .endOfBurst    (endOfBurst)
  );

endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;
  localparam int COL_W = 8;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cmdValid;
  logic [COL_W-1:0] cmdCol;
  logic [2:0]       cmdLen;
  logic             cmdInterleave;
  logic             termIn;
  logic [COL_W-1:0] colOut;
  logic             colValid;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit mActive;
  int mStart, mBeat, mLen;   // mLen 0 = full page
  bit mIlv;

  always #4 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCol(cmdCol),
    .cmdLen(cmdLen), .cmdInterleave(cmdInterleave), .termIn(termIn),
    .colOut(colOut), .colValid(colValid)
  );

  function automatic int decodeLen(logic [2:0] code);
    case (code)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int expAddr(int start, int beat, int blen, bit ilv);
    int m = (blen == 0) ? PAGE - 1 : blen - 1;
    int low = ilv ? ((start ^ beat) & m) : ((start + beat) & m);
    return (start & ~m & (PAGE - 1)) | low;
  endfunction

  task automatic checkOut(string req, bit expV, int expC);
    checks++;
    if (colValid !== expV) begin
      errors++;
      $display("FAIL %s colValid act=%0b exp=%0b", req, colValid, expV);
    end else if (expV && (colOut !== COL_W'(expC))) begin
      errors++;
      $display("FAIL %s colOut act=%0h exp=%0h", req, colOut, expC);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check at next negedge
  task automatic cyc(bit cv, int col, logic [2:0] len, bit il, bit tm);
    string tag;
    cmdValid = cv; cmdCol = COL_W'(col); cmdLen = len;
    cmdInterleave = il; termIn = tm;
    @(posedge clk);
    if (cv) begin
      mActive = 1; mStart = col & (PAGE - 1); mBeat = 0;
      mLen = decodeLen(len); mIlv = il && (len != 3'd7);
    end else if (tm) begin
      mActive = 0;
    end else if (mActive) begin
      if (mLen != 0 && mBeat == mLen - 1) mActive = 0;
      else mBeat = (mBeat + 1) % PAGE;
    end
    @(negedge clk);
    if (cv)               tag = "R2";
    else if (tm)          tag = "R7";
    else if (!mActive)    tag = "R3";
    else if (mLen == 0)   tag = "R6";
    else if (mLen == 1)   tag = "R8";
    else if (mIlv)        tag = "R5";
    else                  tag = "R4";
    checkOut(tag, mActive, expAddr(mStart, mBeat, mLen, mIlv));
  endtask

  task automatic idle(); cyc(0, 0, 3'd0, 0, 0); endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int ilvLit[8] = '{'h35, 'h34, 'h37, 'h36, 'h31, 'h30, 'h33, 'h32};
    int seqLit[8] = '{'h35, 'h36, 'h37, 'h30, 'h31, 'h32, 'h33, 'h34};
    void'($urandom(32'd1234));
    rstN = 0; cmdValid = 0; cmdCol = '0; cmdLen = '0;
    cmdInterleave = 0; termIn = 0; mActive = 0;
    repeat (3) @(negedge clk);
    checkOut("R1", 0, 0);
    rstN = 1;
    @(negedge clk);
    checkOut("R1", 0, 0);

    // R8: length 1, and reserved codes act as length 1
    cyc(1, 'h4A, 3'd0, 0, 0); checkOut("R8", 1, 'h4A);
    idle();                   checkOut("R8", 0, 0);
    cyc(1, 'h11, 3'd5, 1, 0); idle(); checkOut("R3", 0, 0);

    // R4: sequential 8, literal values
    cyc(1, 'h35, 3'd3, 0, 0); checkOut("R4", 1, seqLit[0]);
    for (int i = 1; i < 8; i++) begin idle(); checkOut("R4", 1, seqLit[i]); end
    idle(); checkOut("R3", 0, 0);

    // R5: interleaved 8, literal values
    cyc(1, 'h35, 3'd3, 1, 0); checkOut("R5", 1, ilvLit[0]);
    for (int i = 1; i < 8; i++) begin idle(); checkOut("R5", 1, ilvLit[i]); end
    idle(); checkOut("R3", 0, 0);

    // R4/R5 with lengths 2 and 4
    cyc(1, 'hC3, 3'd1, 0, 0); idle(); checkOut("R4", 1, 'hC2);
    cyc(1, 'hC2, 3'd2, 1, 0); idle(); idle(); checkOut("R5", 1, 'hC0);

    // R6: full page wraps past the top, interleave flag ignored
    cyc(1, 'hFE, 3'd7, 1, 0); idle(); checkOut("R6", 1, 'hFF);
    idle(); checkOut("R6", 1, 'h00);
    for (int i = 0; i < 300; i++) idle();
    checkOut("R6", 1, ('hFE + 302) % PAGE);

    // R7: terminate mid-page, then terminate while idle
    cyc(0, 0, 3'd0, 0, 1); checkOut("R7", 0, 0);
    cyc(0, 0, 3'd0, 0, 1); checkOut("R7", 0, 0);
    idle();

    // R7: command beats terminate in the same cycle
    cyc(1, 'h20, 3'd3, 0, 0); idle();
    cyc(1, 'h77, 3'd2, 0, 1); checkOut("R7", 1, 'h77);

    // R2: interrupt mid-burst
    idle();
    cyc(1, 'h09, 3'd3, 1, 0); checkOut("R2", 1, 'h09);
    idle(); checkOut("R2", 1, 'h08);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit cv = ($urandom_range(0, 7) == 0);
      bit tm = ($urandom_range(0, 31) == 0);
      logic [2:0] ln = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0 && ln > 3) ln = 3'd7;
      cyc(cv, int'($urandom_range(0, PAGE - 1)), ln, 1'($urandom_range(0, 1)), tm);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule